// File: doc/BRIEF.md
# Vector Operation Sequencer

This block is the control core of a vector arithmetic coprocessor. A host configures it through a small write-only register bus. The configuration covers the vector length, the base addresses of the source and result vectors, two scalar operands and a short program of up to eight arithmetic steps. The base addresses and the length are passed through to an external memory streaming engine. After a start command, the sequencer takes one entry per vector element from a read FIFO. Each entry carries two 32-bit lanes, one element from each of two source vectors. The sequencer then runs every programmed step on that element.

Each step names an opcode, two operand sources and a destination in an eight-entry register file. It may also mark its result for output. Operands come from the register file, the two FIFO lanes or the two host scalars. Steps go out to an external pipelined arithmetic unit with a fixed latency. A step is held back only while one of its registers still waits for a result. This lets the steps of the next element overlap the steps of the current one. Results marked for output go to a write FIFO in program order. The host can read any register at any time.

Running the same program again on new data takes four writes: both scalars, the result base address and a start.

Top module: `vseq_top`

## Requirements
- R1: After reset, busy, done, op_valid, rd_pop and wf_push are low, and every register of the file reads zero on host_rdata.
- R2: Host write addresses are: 0 length, 1 source base, 2 result base, 3 scalar A, 4 scalar B, 5 step count, 6 start, and 8+i program slot i. xfer_len, src_base and dst_base show the stored values. Every host write made while busy is high has no effect.
- R3: A start write while idle raises busy on the next cycle. busy drops in the cycle after the last issued operation's result is accepted, and done is high for exactly that one cycle. With length 0, busy rises, then falls with done, and no operation is issued.
- R4: Each element pops exactly one read FIFO entry, when its first step issues, and rd_pop is never high without rd_valid. Source code 8 selects rd_data[31:0], 9 selects rd_data[63:32], 0-7 select a register, 10 selects scalar A, 11 selects scalar B, and 12-15 give zero. Later steps of the same element see the lanes that were popped.
- R5: A program slot holds bits [15:12] opcode, [11:8] source A, [7:4] source B, [3:1] destination register and [0] output flag. A step count of 0 runs one step, counts above 8 run eight, and slots past the count are never issued.
- R6: Every accepted result is written to its destination register. A result whose output flag is set is pushed to the write FIFO. The pushed sequence equals the in-order evaluation of the program over the elements.
- R7: A step issues only when neither of its register sources nor its destination has a result outstanding. Steps with no such conflict issue on consecutive cycles, one per cycle.
- R8: Issue stalls while the read FIFO is empty for a first step. When an output result meets a full write FIFO, op_hold freezes the arithmetic pipeline and no step issues. No result is lost or duplicated.
- R9: Configuration is kept between runs. Only scalar, result base and start writes are needed to run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 3 | Register file index for host read |
| host_rdata | output | 32 | Selected register value |
| busy | output | 1 | A vector pass is in progress |
| done | output | 1 | One-cycle pulse when a pass completes |
| xfer_len | output | 16 | Stored vector length |
| src_base | output | 32 | Stored source vector base address |
| dst_base | output | 32 | Stored result vector base address |
| rd_valid | input | 1 | Read FIFO holds an entry |
| rd_data | input | 64 | Read FIFO head: two 32-bit lanes |
| rd_pop | output | 1 | Consume the read FIFO head |
| wf_full | input | 1 | Write FIFO cannot accept |
| wf_push | output | 1 | Push wf_data into the write FIFO |
| wf_data | output | 32 | Result pushed to the write FIFO |
| op_valid | output | 1 | An operation is issued this cycle |
| op_code | output | 4 | Opcode of the issued operation |
| op_a | output | 32 | First operand |
| op_b | output | 32 | Second operand |
| op_tag | output | 4 | {destination register, output flag} carried with the operation |
| op_hold | output | 1 | Freeze the arithmetic pipeline |
| res_valid | input | 1 | Result at the pipeline end |
| res_data | input | 32 | Result value |
| res_tag | input | 4 | Tag returned with the result |

## Verification
A distance program (two subtracts, two squares, a sum and a root) runs with register dependencies between steps. If hazard detection is wrong, a step reads a stale register and the scoreboard sees a wrong value. One run combines random FIFO gaps with a write FIFO that turns full at random. A design that issues into a frozen pipeline, or pops twice, loses or repeats results. An eight-step independent program must issue sixteen operations back to back, so a needlessly conservative hazard check shows up as gaps. Further cases cover a zero length, a zero or oversized step count, zero-source codes and writes made while busy. In these cases a faulty design hangs, issues stray operations or changes its configuration.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int DW    = 32;
    localparam int AW    = 32;
    localparam int LENW  = 16;
    localparam int NREG  = 8;
    localparam int RIW   = $clog2(NREG);
    localparam int NSTEP = 8;
    localparam int SIW   = $clog2(NSTEP);
    localparam int TAGW  = RIW + 1;

    // operand source codes (0..NREG-1 are registers)
    localparam logic [3:0] SRC_LANE0 = 4'd8;
    localparam logic [3:0] SRC_LANE1 = 4'd9;
    localparam logic [3:0] SRC_SCA   = 4'd10;
    localparam logic [3:0] SRC_SCB   = 4'd11;

    // host write map
    localparam logic [3:0] HA_LEN  = 4'd0;
    localparam logic [3:0] HA_SRC  = 4'd1;
    localparam logic [3:0] HA_DST  = 4'd2;
    localparam logic [3:0] HA_SCA  = 4'd3;
    localparam logic [3:0] HA_SCB  = 4'd4;
    localparam logic [3:0] HA_CNT  = 4'd5;
    localparam logic [3:0] HA_GO   = 4'd6;

    typedef struct packed {
        logic [3:0]     op;
        logic [3:0]     sa;
        logic [3:0]     sb;
        logic [RIW-1:0] dst;
        logic           to_out;
    } step_t;

    typedef struct packed {
        logic [RIW-1:0] dst;
        logic           to_out;
    } tag_t;

    function automatic logic is_reg(input logic [3:0] s);
        return !s[3];
    endfunction

    function automatic logic [SIW-1:0] last_of(input logic [3:0] v);
        if (v == 4'd0) return '0;
        if (int'(v) > NSTEP) return SIW'(NSTEP - 1);
        return SIW'(v - 4'd1);
    endfunction

    function automatic logic [DW-1:0] pick(
        input logic [3:0]                s,
        input logic [NREG-1:0][DW-1:0]   r,
        input logic [2*DW-1:0]           lanes,
        input logic [DW-1:0]             sca,
        input logic [DW-1:0]             scb
    );
        if (is_reg(s)) return r[s[RIW-1:0]];
        case (s)
            SRC_LANE0: return lanes[DW-1:0];
            SRC_LANE1: return lanes[2*DW-1:DW];
            SRC_SCA:   return sca;
            SRC_SCB:   return scb;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/vseq_cfg.sv
module vseq_cfg
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    output logic              go,
    output logic [LENW-1:0]   len,
    output logic [AW-1:0]     src_base,
    output logic [AW-1:0]     dst_base,
    output logic [DW-1:0]     sca,
    output logic [DW-1:0]     scb,
    output logic [SIW-1:0]    last_step,
    output step_t             prog [NSTEP]
);
    logic acc;
    assign acc = we && !busy;
    assign go  = acc && (addr == HA_GO);

    always_ff @(posedge clk) begin
        if (rst) begin
            len       <= '0;
            src_base  <= '0;
            dst_base  <= '0;
            sca       <= '0;
            scb       <= '0;
            last_step <= '0;
            for (int i = 0; i < NSTEP; i++) prog[i] <= '0;
        end else if (acc) begin
            if (addr[3]) begin
                prog[addr[SIW-1:0]] <= step_t'(wdata[$bits(step_t)-1:0]);
            end else begin
                case (addr)
                    HA_LEN: len       <= wdata[LENW-1:0];
                    HA_SRC: src_base  <= wdata;
                    HA_DST: dst_base  <= wdata;
                    HA_SCA: sca       <= wdata;
                    HA_SCB: scb       <= wdata;
                    HA_CNT: last_step <= last_of(wdata[3:0]);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vseq_rf.sv
module vseq_rf
    import vseq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    iss,
    input  logic [RIW-1:0]          iss_dst,
    input  logic                    ret,
    input  logic [RIW-1:0]          ret_dst,
    input  logic [DW-1:0]           ret_data,
    output logic [NREG-1:0][DW-1:0] regs,
    output logic [NREG-1:0]         pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
            pend <= '0;
        end else begin
            if (ret) regs[ret_dst] <= ret_data;
            for (int i = 0; i < NREG; i++) begin
                if (iss && iss_dst == RIW'(i))      pend[i] <= 1'b1;
                else if (ret && ret_dst == RIW'(i)) pend[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vseq_issue.sv
module vseq_issue
    import vseq_pkg::*;
#(
    parameter int FLW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  logic [LENW-1:0]         len,
    input  logic [SIW-1:0]          last_step,
    input  step_t                   prog [NSTEP],
    input  logic [DW-1:0]           sca,
    input  logic [DW-1:0]           scb,
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [NREG-1:0]         pend,
    input  logic                    rd_valid,
    input  logic [2*DW-1:0]         rd_data,
    input  logic                    hold,
    input  logic                    ret,
    output logic                    issue,
    output step_t                   cur,
    output logic [DW-1:0]           opa,
    output logic [DW-1:0]           opb,
    output logic                    rd_pop,
    output logic                    busy,
    output logic                    done
);
    logic [LENW-1:0] elem;
    logic [SIW-1:0]  sidx;
    logic [2*DW-1:0] lanes_q, lanes;
    logic [FLW-1:0]  inflight;
    logic            first, conflict, more, finish;

    assign cur   = prog[sidx];
    assign first = (sidx == '0);
    assign lanes = first ? rd_data : lanes_q;

    assign conflict = (is_reg(cur.sa) && pend[cur.sa[RIW-1:0]])
                   || (is_reg(cur.sb) && pend[cur.sb[RIW-1:0]])
                   || pend[cur.dst];
    assign more   = busy && (elem != len);
    assign issue  = more && (!first || rd_valid) && !conflict && !hold;
    assign rd_pop = issue && first;
    assign finish = busy && !more && (inflight == '0);

    assign opa = pick(cur.sa, regs, lanes, sca, scb);
    assign opb = pick(cur.sb, regs, lanes, sca, scb);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            elem     <= '0;
            sidx     <= '0;
            lanes_q  <= '0;
            inflight <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1;
                    elem <= '0;
                    sidx <= '0;
                end
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
            if (issue) begin
                if (first) lanes_q <= rd_data;
                if (sidx == last_step) begin
                    sidx <= '0;
                    elem <= elem + LENW'(1);
                end else begin
                    sidx <= sidx + SIW'(1);
                end
            end
            case ({issue, ret})
                2'b10:   inflight <= inflight + FLW'(1);
                2'b01:   inflight <= inflight - FLW'(1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vseq_top.sv
module vseq_top
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [3:0]        host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic [RIW-1:0]    host_raddr,
    output logic [DW-1:0]     host_rdata,
    output logic              busy,
    output logic              done,
    output logic [LENW-1:0]   xfer_len,
    output logic [AW-1:0]     src_base,
    output logic [AW-1:0]     dst_base,
    input  logic              rd_valid,
    input  logic [2*DW-1:0]   rd_data,
    output logic              rd_pop,
    input  logic              wf_full,
    output logic              wf_push,
    output logic [DW-1:0]     wf_data,
    output logic              op_valid,
    output logic [3:0]        op_code,
    output logic [DW-1:0]     op_a,
    output logic [DW-1:0]     op_b,
    output logic [TAGW-1:0]   op_tag,
    output logic              op_hold,
    input  logic              res_valid,
    input  logic [DW-1:0]     res_data,
    input  logic [TAGW-1:0]   res_tag
);
    logic                    go, ret;
    logic [DW-1:0]           sca, scb;
    logic [SIW-1:0]          last_step;
    step_t                   prog [NSTEP];
    step_t                   cur;
    tag_t                    rtag;
    logic [NREG-1:0][DW-1:0] regs;
    logic [NREG-1:0]         pend;

    assign rtag    = tag_t'(res_tag);
    assign op_hold = res_valid && rtag.to_out && wf_full;
    assign ret     = res_valid && !op_hold;
    assign wf_push = res_valid && rtag.to_out && !wf_full;
    assign wf_data = res_data;
    assign op_code = cur.op;
    assign op_tag  = {cur.dst, cur.to_out};
    assign host_rdata = regs[host_raddr];

    vseq_cfg u_cfg (
        .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .busy(busy), .go(go), .len(xfer_len), .src_base(src_base), .dst_base(dst_base),
        .sca(sca), .scb(scb), .last_step(last_step), .prog(prog)
    );

    vseq_rf u_rf (
        .clk(clk), .rst(rst), .iss(op_valid), .iss_dst(cur.dst),
        .ret(ret), .ret_dst(rtag.dst), .ret_data(res_data),
        .regs(regs), .pend(pend)
    );

    vseq_issue u_iss (
        .clk(clk), .rst(rst), .go(go), .len(xfer_len), .last_step(last_step),
        .prog(prog), .sca(sca), .scb(scb), .regs(regs), .pend(pend),
        .rd_valid(rd_valid), .rd_data(rd_data), .hold(op_hold), .ret(ret),
        .issue(op_valid), .cur(cur), .opa(op_a), .opb(op_b),
        .rd_pop(rd_pop), .busy(busy), .done(done)
    );
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk
    import vseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       host_we,
    input logic [3:0] host_addr,
    input logic       busy,
    input logic       done,
    input logic       rd_valid,
    input logic       rd_pop,
    input logic       wf_full,
    input logic       wf_push,
    input logic       op_valid,
    input logic       op_hold,
    input logic       res_valid,
    input logic       res_out
);
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && host_we && host_addr == HA_GO) |=> busy);
    a_r3_done_with_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!op_valid && !rd_pop));
    a_r4_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
        rd_pop |-> rd_valid);
    a_r6_push_from_result: assert property (@(posedge clk) disable iff (rst)
        wf_push |-> (res_valid && res_out));
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
        wf_full |-> !wf_push);
    a_r8_hold_blocks_issue: assert property (@(posedge clk) disable iff (rst)
        op_hold |-> !op_valid);
    a_r8_hold_cause: assert property (@(posedge clk) disable iff (rst)
        op_hold |-> (res_valid && res_out && wf_full));
endmodule

bind vseq_top vseq_chk u_chk (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_pop(rd_pop),
    .wf_full(wf_full), .wf_push(wf_push), .op_valid(op_valid),
    .op_hold(op_hold), .res_valid(res_valid), .res_out(res_tag[0])
);

// File: tb/sim_vseq_top.sv
module sim_vseq_top;
    import vseq_pkg::*;
    localparam int LAT = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [RIW-1:0] host_raddr = '0;
    logic [DW-1:0] host_rdata;
    logic busy, done, rd_pop, wf_push, op_valid, op_hold;
    logic [LENW-1:0] xfer_len;
    logic [AW-1:0] src_base, dst_base;
    logic rd_valid = 1'b0;
    logic [2*DW-1:0] rd_data = '0;
    logic wf_full = 1'b0;
    logic [DW-1:0] wf_data, op_a, op_b;
    logic [3:0] op_code;
    logic [TAGW-1:0] op_tag;
    logic res_valid = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [TAGW-1:0] res_tag = '0;

    vseq_top u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .busy(busy), .done(done), .xfer_len(xfer_len), .src_base(src_base),
        .dst_base(dst_base), .rd_valid(rd_valid), .rd_data(rd_data), .rd_pop(rd_pop),
        .wf_full(wf_full), .wf_push(wf_push), .wf_data(wf_data),
        .op_valid(op_valid), .op_code(op_code), .op_a(op_a), .op_b(op_b),
        .op_tag(op_tag), .op_hold(op_hold), .res_valid(res_valid),
        .res_data(res_data), .res_tag(res_tag)
    );

    int total = 0, bad = 0;
    int cyc = 0, issues = 0, pushes = 0, holds = 0, first_iss = -1, last_iss = -1;
    bit gate_rd = 0, gate_wf = 0;
    logic [15:0] lf = 16'hACE1;
    logic [2*DW-1:0] rdq [$];
    logic [DW-1:0]   expq [$];
    logic            pv [LAT];
    logic [DW-1:0]   pd [LAT];
    logic [TAGW-1:0] pt [LAT];

    step_t         bprog [NSTEP];
    logic [SIW-1:0] blast = '0;
    logic [DW-1:0] bsca = '0, bscb = '0;
    logic [DW-1:0] bregs [NREG];

    function automatic logic [DW-1:0] isqrt(input logic [DW-1:0] a);
        longint r = 0;
        while ((r + 1) * (r + 1) <= longint'(a)) r++;
        return DW'(r);
    endfunction

    function automatic logic [DW-1:0] alu(input logic [3:0] op, input logic [DW-1:0] a, b);
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a * b;
            4'd3: return isqrt(a);
            default: return a;
        endcase
    endfunction

    function automatic logic [DW-1:0] bsrc(input logic [3:0] s, input logic [2*DW-1:0] ln);
        if (s < 4'd8) return bregs[s[2:0]];
        case (s)
            4'd8:  return ln[DW-1:0];
            4'd9:  return ln[2*DW-1:DW];
            4'd10: return bsca;
            4'd11: return bscb;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle process: FIFO models, operator pipeline, scoreboard monitor, watchdog
    always @(negedge clk) begin
        cyc++;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rd_valid  = (rdq.size() > 0) && !(gate_rd && lf[0]);
        rd_data   = (rdq.size() > 0) ? rdq[0] : '0;
        wf_full   = gate_wf && lf[3];
        res_valid = pv[LAT-1];
        res_data  = pd[LAT-1];
        res_tag   = pt[LAT-1];
        #1;
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pd[i] = '0; pt[i] = '0; end
        end else begin
            if (rd_pop) void'(rdq.pop_front());
            if (wf_push) begin
                pushes++;
                if (expq.size() == 0) chk(0, "R6", "unexpected push", wf_data, '0);
                else begin
                    logic [DW-1:0] e;
                    e = expq.pop_front();
                    chk(wf_data == e, "R6", "pushed result", wf_data, e);
                end
            end
            if (op_hold) holds++;
            else begin
                for (int i = LAT - 1; i > 0; i--) begin
                    pv[i] = pv[i-1]; pd[i] = pd[i-1]; pt[i] = pt[i-1];
                end
                pv[0] = op_valid;
                pd[0] = alu(op_code, op_a, op_b);
                pt[0] = op_tag;
                if (op_valid) begin
                    issues++;
                    if (first_iss < 0) first_iss = cyc;
                    last_iss = cyc;
                end
            end
        end
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rdreg(input logic [RIW-1:0] i, output logic [DW-1:0] v);
        @(negedge clk);
        host_raddr = i;
        #1 v = host_rdata;
    endtask

    task automatic ld_step(input int i, input logic [3:0] op, input logic [3:0] sa,
                           input logic [3:0] sb, input logic [2:0] d, input logic o);
        bprog[i] = step_t'({op, sa, sb, d, o});
        wr(4'd8 + 4'(i), {16'h0, 16'(bprog[i])});
    endtask

    task automatic ld_cnt(input logic [3:0] n);
        wr(HA_CNT, {28'h0, n});
        blast = (n == 0) ? 3'd0 : (n > 8) ? 3'd7 : 3'(n - 1);
    endtask

    // driver: fills read FIFO and pushes expected outputs from a sequential model
    task automatic feed(input int n, input int seed);
        for (int e = 0; e < n; e++) begin
            logic [2*DW-1:0] ln;
            ln = {DW'(seed * 3 + e * 5 + 2), DW'(seed + e * 7 + 1)};
            rdq.push_back(ln);
            for (int s = 0; s <= int'(blast); s++) begin
                logic [DW-1:0] r;
                r = alu(bprog[s].op, bsrc(bprog[s].sa, ln), bsrc(bprog[s].sb, ln));
                bregs[bprog[s].dst] = r;
                if (bprog[s].to_out) expq.push_back(r);
            end
        end
    endtask

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int k = 0; k < 4000 && !seen; k++) begin
            @(negedge clk);
            #1 if (done) seen = 1;
        end
        chk(seen, req, "done pulse seen", 32'(seen), 1);
        @(negedge clk);
        #1 chk(!busy, req, "busy low after done", 32'(busy), 0);
    endtask

    task automatic start_chk(input string req);
        wr(HA_GO, 0);
        #1 chk(busy, req, "busy after start", 32'(busy), 1);
    endtask

    initial begin
        logic [DW-1:0] v;
        for (int i = 0; i < NREG; i++) bregs[i] = '0;
        for (int i = 0; i < NSTEP; i++) bprog[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        chk(!op_valid && !rd_pop && !wf_push, "R1", "strobes after reset",
            {op_valid, rd_pop, wf_push}, 0);
        rdreg(0, v); chk(v == 0, "R1", "reg0 reset", v, 0);
        rdreg(5, v); chk(v == 0, "R1", "reg5 reset", v, 0);

        // R2 configuration map, distance program
        wr(HA_LEN, 5); wr(HA_SRC, 32'h1000); wr(HA_DST, 32'h2000);
        wr(HA_SCA, 3); bsca = 3; wr(HA_SCB, 4); bscb = 4;
        ld_step(0, 4'd1, 4'd8, 4'd10, 3'd0, 1'b0);
        ld_step(1, 4'd1, 4'd9, 4'd11, 3'd1, 1'b0);
        ld_step(2, 4'd2, 4'd0, 4'd0, 3'd2, 1'b0);
        ld_step(3, 4'd2, 4'd1, 4'd1, 3'd3, 1'b0);
        ld_step(4, 4'd0, 4'd2, 4'd3, 3'd4, 1'b0);
        ld_step(5, 4'd3, 4'd4, 4'd12, 3'd5, 1'b1);
        ld_cnt(6);
        #1;
        chk(xfer_len == 5, "R2", "length port", 32'(xfer_len), 5);
        chk(src_base == 32'h1000, "R2", "source base port", src_base, 32'h1000);
        chk(dst_base == 32'h2000, "R2", "result base port", dst_base, 32'h2000);

        // R6/R7 run with register dependencies
        pushes = 0;
        feed(5, 10);
        start_chk("R3");
        wait_done("R3");
        chk(expq.size() == 0 && pushes == 5, "R6", "pushed count", 32'(pushes), 5);
        rdreg(5, v); chk(v == bregs[5], "R6", "host read reg5", v, bregs[5]);
        rdreg(0, v); chk(v == bregs[0], "R6", "host read reg0", v, bregs[0]);

        // R9 rerun with four writes, R8 random FIFO stalls
        gate_rd = 1; gate_wf = 1; holds = 0; pushes = 0;
        wr(HA_SCA, 20); bsca = 20; wr(HA_SCB, 1); bscb = 1; wr(HA_DST, 32'h3000);
        feed(5, 40);
        start_chk("R9");
        wait_done("R8");
        chk(expq.size() == 0 && pushes == 5, "R8", "no loss under stalls", 32'(pushes), 5);
        chk(holds > 0, "R8", "hold exercised", 32'(holds), 1);
        chk(dst_base == 32'h3000 && src_base == 32'h1000, "R9", "bases retained",
            src_base, 32'h1000);
        gate_rd = 0; gate_wf = 0;

        // R2 writes while busy are ignored
        pushes = 0;
        feed(5, 70);
        start_chk("R2");
        wr(HA_LEN, 99);
        wr(4'd8, 32'h0000_FFFF);
        wait_done("R2");
        #1 chk(xfer_len == 5, "R2", "length kept while busy", 32'(xfer_len), 5);
        chk(expq.size() == 0 && pushes == 5, "R2", "program kept while busy", 32'(pushes), 5);

        // R7 independent steps issue back to back
        for (int i = 0; i < 8; i++)
            ld_step(i, 4'(i % 3), 4'd8, (i % 2 == 0) ? 4'd9 : 4'd10, 3'(i), 1'b1);
        ld_cnt(8);
        wr(HA_LEN, 2);
        issues = 0; first_iss = -1; pushes = 0;
        feed(2, 5);
        start_chk("R7");
        wait_done("R7");
        chk(issues == 16, "R7", "issue count", 32'(issues), 16);
        chk(last_iss - first_iss + 1 == 16, "R7", "back-to-back span",
            32'(last_iss - first_iss + 1), 16);
        chk(expq.size() == 0 && pushes == 16, "R6", "independent outputs", 32'(pushes), 16);

        // R5 step count 0 runs one step, zero source code
        ld_step(0, 4'd0, 4'd8, 4'd13, 3'd6, 1'b1);
        ld_cnt(0);
        wr(HA_LEN, 3);
        pushes = 0; issues = 0;
        feed(3, 9);
        start_chk("R5");
        wait_done("R5");
        chk(issues == 3 && pushes == 3, "R5", "count 0 is one step", 32'(issues), 3);
        chk(expq.size() == 0, "R4", "zero source", 32'(expq.size()), 0);

        // R5 oversized count clamps to eight
        ld_cnt(4'd12);
        wr(HA_LEN, 1);
        issues = 0;
        feed(1, 2);
        start_chk("R5");
        wait_done("R5");
        chk(issues == 8, "R5", "count clamped to 8", 32'(issues), 8);
        chk(expq.size() == 0 && rdq.size() == 0, "R4", "one pop per element",
            32'(rdq.size()), 0);

        // R3 zero length
        wr(HA_LEN, 0);
        issues = 0; pushes = 0;
        start_chk("R3");
        wait_done("R3");
        chk(issues == 0 && pushes == 0, "R3", "zero length issues nothing", 32'(issues), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule